// File: doc/BRIEF.md
# Shared GPIO Drive and Enable Register Bank

This block keeps two 32-bit registers for a general-purpose I/O bank. One holds the level each pin drives and the other holds which pins drive at all. Two processor cores share the block, and each core has its own write port. A write names one of the two registers and one of four operations: replace the whole value, set the masked bits, clear the masked bits, or invert the masked bits. Each core also has a read port that returns either register.

Both cores can write on the same clock cycle. When they target the same register, the block computes in one cycle the value that results from applying core 0's operation and then core 1's operation to that result. Only that final value is stored. The partial result is never registered and never reaches a pin. When the two cores target different registers, the writes do not affect each other.

Top module: `gpio_dual_out_bank`

## Requirements
- R1: While `rst_n` is low, both `gpio_out` and `gpio_oe` are 0. `rst_n` is asserted asynchronously and released on a clock edge.
- R2: A write with op code 0 replaces the selected register with `wdata`. The new value appears after the next rising clock edge.
- R3: A write with op code 1 ORs `wdata` into the selected register. Bits outside the mask keep their value.
- R4: A write with op code 2 clears the selected register's bits where `wdata` is 1. Bits outside the mask keep their value.
- R5: A write with op code 3 inverts the selected register's bits where `wdata` is 1. Bits outside the mask keep their value.
- R6: When both cores write the same register on the same cycle, the stored value equals core 1's operation applied to the result of core 0's operation. For example, core 0 setting a bit while core 1 inverts the same bit leaves that bit at 0, whatever its prior value.
- R7: A same-cycle merged write changes the output exactly once, at the clock edge. A pin that starts at 0, with core 0 setting it and core 1 inverting it, stays low at every sample in the following cycles.
- R8: Same-cycle writes from the two cores to different registers each take effect as if they were alone. A register that no write targets keeps its value.
- R9: A cycle with no valid write leaves both registers unchanged.
- R10: Each core's `rdata` returns `gpio_out` when its `rsel` is 0 and `gpio_oe` when its `rsel` is 1. Bit n of the result corresponds to GPIO n.
- R11: On the write ports, `wsel` = 0 selects the drive-level register and `wsel` = 1 selects the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| c0_wvalid | input | 1 | Core 0 write strobe |
| c0_wop | input | 2 | Core 0 operation: 0 replace, 1 set, 2 clear, 3 invert |
| c0_wsel | input | 1 | Core 0 target: 0 level, 1 enable |
| c0_wdata | input | 32 | Core 0 value or mask |
| c1_wvalid | input | 1 | Core 1 write strobe |
| c1_wop | input | 2 | Core 1 operation code |
| c1_wsel | input | 1 | Core 1 target register |
| c1_wdata | input | 32 | Core 1 value or mask |
| c0_rsel | input | 1 | Core 0 read select |
| c0_rdata | output | 32 | Core 0 read data |
| c1_rsel | input | 1 | Core 1 read select |
| c1_rdata | output | 32 | Core 1 read data |
| gpio_out | output | 32 | Driven level per pin |
| gpio_oe | output | 32 | Drive enable per pin |

## Verification
A wrong merge order or a mis-decoded operation shows up on `gpio_out` or `gpio_oe` one clock edge after the write, since each register is a single flop stage with no pipeline. An incorrect register select shows up as a change in the register that no write targeted, visible in that same cycle. A partial result that leaked into storage would appear as a one-cycle pulse on the pin, so the glitch scenario samples the pin over several half-cycles after the merged write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_XOR   = 2'd3
  } gpio_op_e;

  localparam int unsigned REG_LEVEL  = 0;
  localparam int unsigned REG_ENABLE = 1;
  localparam int unsigned NUM_REGS   = 2;

endpackage

// File: rtl/gpio_alias_stage.sv
module gpio_alias_stage
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             apply_en,
  input  gpio_op_e         op,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  logic [WIDTH-1:0] result;

  always_comb begin
    unique case (op)
      OP_WRITE: result = mask;
      OP_SET:   result = cur | mask;
      OP_CLR:   result = cur & ~mask;
      OP_XOR:   result = cur ^ mask;
      default:  result = cur;
    endcase
    nxt = apply_en ? result : cur;
  end

endmodule

// File: rtl/gpio_reg_lane.sv
module gpio_reg_lane
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NCORE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] hit,
  input  gpio_op_e         op   [NCORE],
  input  logic [WIDTH-1:0] mask [NCORE],
  output logic [WIDTH-1:0] q
);

  localparam int unsigned LAST = NCORE - 1;

  logic [WIDTH-1:0] chain [NCORE+1];
  logic [WIDTH-1:0] q_d;
  logic             q_en;

  assign chain[0] = q;

  // Core order is priority: lower index applied first, later cores see its result.
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    gpio_alias_stage #(.WIDTH(WIDTH)) u_stage (
      .apply_en (hit[c]),
      .op       (op[c]),
      .mask     (mask[c]),
      .cur      (chain[c]),
      .nxt      (chain[c+1])
    );
  end

  always_comb begin
    q_en = |hit;
    q_d  = chain[NCORE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_d;
    end
  end

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> $stable(q));

  p_last_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[LAST] && op[LAST] == OP_WRITE) |=> (q == $past(mask[LAST])));

  p_last_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[LAST] && op[LAST] == OP_SET) |=> ((q & $past(mask[LAST])) == $past(mask[LAST])));

  p_last_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[LAST] && op[LAST] == OP_CLR) |=> ((q & $past(mask[LAST])) == '0));

  p_lone_xor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hit) == 1 && hit[LAST] && op[LAST] == OP_XOR)
      |=> (q == ($past(q) ^ $past(mask[LAST]))));

  p_set_then_xor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (NCORE == 2 && hit[0] && hit[LAST] && op[0] == OP_SET && op[LAST] == OP_XOR)
      |=> ((q & $past(mask[0]) & $past(mask[LAST])) == '0));

endmodule

// File: rtl/gpio_dual_out_bank.sv
module gpio_dual_out_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             c0_wvalid,
  input  logic [1:0]       c0_wop,
  input  logic             c0_wsel,
  input  logic [WIDTH-1:0] c0_wdata,
  input  logic             c1_wvalid,
  input  logic [1:0]       c1_wop,
  input  logic             c1_wsel,
  input  logic [WIDTH-1:0] c1_wdata,
  input  logic             c0_rsel,
  output logic [WIDTH-1:0] c0_rdata,
  input  logic             c1_rsel,
  output logic [WIDTH-1:0] c1_rdata,
  output logic [WIDTH-1:0] gpio_out,
  output logic [WIDTH-1:0] gpio_oe
);

  localparam int unsigned NCORE = 2;

  logic             wvalid [NCORE];
  logic             wsel   [NCORE];
  gpio_op_e         wop    [NCORE];
  logic [WIDTH-1:0] wdata  [NCORE];
  logic [WIDTH-1:0] regq   [NUM_REGS];

  always_comb begin
    wvalid[0] = c0_wvalid;  wvalid[1] = c1_wvalid;
    wsel[0]   = c0_wsel;    wsel[1]   = c1_wsel;
    wop[0]    = gpio_op_e'(c0_wop);
    wop[1]    = gpio_op_e'(c1_wop);
    wdata[0]  = c0_wdata;   wdata[1]  = c1_wdata;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [NCORE-1:0] hit;
    for (genvar c = 0; c < NCORE; c++) begin : g_hit
      assign hit[c] = wvalid[c] && (wsel[c] == r[0]);
    end
    gpio_reg_lane #(.WIDTH(WIDTH), .NCORE(NCORE)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (hit),
      .op   (wop),
      .mask (wdata),
      .q    (regq[r])
    );
  end

  assign gpio_out = regq[REG_LEVEL];
  assign gpio_oe  = regq[REG_ENABLE];
  assign c0_rdata = c0_rsel ? regq[REG_ENABLE] : regq[REG_LEVEL];
  assign c1_rdata = c1_rsel ? regq[REG_ENABLE] : regq[REG_LEVEL];

  p_enable_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(c0_wvalid && c0_wsel) && !(c1_wvalid && c1_wsel)) |=> $stable(gpio_oe));

  p_level_untouched_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(c0_wvalid && !c0_wsel) && !(c1_wvalid && !c1_wsel)) |=> $stable(gpio_out));

endmodule

// File: tb/tb_gpio_dual_out_bank.sv
module tb_gpio_dual_out_bank;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         c0_wvalid, c1_wvalid, c0_wsel, c1_wsel, c0_rsel, c1_rsel;
  logic [1:0]   c0_wop, c1_wop;
  logic [W-1:0] c0_wdata, c1_wdata, c0_rdata, c1_rdata, gpio_out, gpio_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  gpio_dual_out_bank #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .c0_wvalid(c0_wvalid), .c0_wop(c0_wop), .c0_wsel(c0_wsel), .c0_wdata(c0_wdata),
    .c1_wvalid(c1_wvalid), .c1_wop(c1_wop), .c1_wsel(c1_wsel), .c1_wdata(c1_wdata),
    .c0_rsel(c0_rsel), .c0_rdata(c0_rdata), .c1_rsel(c1_rsel), .c1_rdata(c1_rdata),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  function automatic logic [W-1:0] ref_op(logic [W-1:0] cur, int op, logic [W-1:0] m);
    case (op)
      0: return m;
      1: return cur | m;
      2: return cur & ~m;
      default: return cur ^ m;
    endcase
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    c0_wvalid = 0; c1_wvalid = 0;
  endtask

  // Drive at negedge, let one posedge register it, sample 1 ns later.
  task automatic wr(input bit v0, int op0, bit s0, logic [W-1:0] d0,
                    input bit v1, int op1, bit s1, logic [W-1:0] d1);
    @(negedge clk);
    c0_wvalid = v0; c0_wop = op0[1:0]; c0_wsel = s0; c0_wdata = d0;
    c1_wvalid = v1; c1_wop = op1[1:0]; c1_wsel = s1; c1_wdata = d1;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic t_reset();
    wr(1, 0, 0, 32'hFFFF_0000, 1, 0, 1, 32'h0000_FFFF);
    #1 rst_n = 0; #1;
    chk("R1 out in reset", gpio_out, '0);
    chk("R1 oe in reset", gpio_oe, '0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 out after release", gpio_out, '0);
  endtask

  task automatic t_single_ops();
    logic [W-1:0] exp = 32'h0F0F_3C3C;
    wr(1, 0, 0, exp, 0, 0, 0, '0);
    chk("R2 write level", gpio_out, exp);
    wr(0, 0, 0, '0, 1, 1, 0, 32'h8000_0001);
    exp = exp | 32'h8000_0001; chk("R3 set level", gpio_out, exp);
    wr(1, 2, 0, 32'h0F00_0C00, 0, 0, 0, '0);
    exp = exp & ~32'h0F00_0C00; chk("R4 clr level", gpio_out, exp);
    wr(1, 3, 0, 32'hFFFF_0000, 0, 0, 0, '0);
    exp = exp ^ 32'hFFFF_0000; chk("R5 xor level", gpio_out, exp);
    wr(0, 0, 0, '0, 1, 0, 1, 32'h1234_5678);
    chk("R11 wsel=1 hits enable", gpio_oe, 32'h1234_5678);
    chk("R11 level untouched", gpio_out, exp);
  endtask

  task automatic t_pair_matrix();
    logic [W-1:0] pre = 32'hC3A5_5A3C;
    logic [W-1:0] m0  = 32'hF0F0_CC33;
    logic [W-1:0] m1  = 32'hFF00_AA55;
    for (int s = 0; s < 2; s++) begin
      for (int o0 = 0; o0 < 4; o0++) begin
        for (int o1 = 0; o1 < 4; o1++) begin
          logic [W-1:0] other = (s == 0) ? gpio_oe : gpio_out;
          logic [W-1:0] exp;
          wr(1, 0, s[0], pre, 0, 0, 0, '0);
          wr(1, o0, s[0], m0, 1, o1, s[0], m1);
          exp = ref_op(ref_op(pre, o0, m0), o1, m1);
          chk($sformatf("R6 pair reg%0d op%0d then op%0d", s, o0, o1),
              (s == 0) ? gpio_out : gpio_oe, exp);
          if (o0 == 0 && o1 == 0)
            chk("R8 other reg untouched", (s == 0) ? gpio_oe : gpio_out, other);
        end
      end
    end
    wr(1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, '0);
    wr(1, 1, 0, 32'h0000_00FF, 1, 3, 0, 32'h0000_00FF);
    chk("R6 set+xor forces 0 from 1", gpio_out & 32'hFF, '0);
  endtask

  task automatic t_glitch();
    wr(1, 0, 0, '0, 0, 0, 0, '0);
    @(negedge clk);
    c0_wvalid = 1; c0_wop = 2'd1; c0_wsel = 0; c0_wdata = 32'h0000_0010;
    c1_wvalid = 1; c1_wop = 2'd3; c1_wsel = 0; c1_wdata = 32'h0000_0010;
    @(posedge clk); #1;
    idle();
    for (int k = 0; k < 4; k++) begin
      chk("R7 pin stays low", gpio_out, '0);
      #1;
    end
  endtask

  task automatic t_independent();
    wr(1, 0, 0, 32'hAAAA_0000, 1, 0, 1, 32'h0000_5555);
    wr(1, 3, 0, 32'h0000_FFFF, 1, 1, 1, 32'hF000_0000);
    chk("R8 level alone", gpio_out, 32'hAAAA_FFFF);
    chk("R8 enable alone", gpio_oe, 32'hF000_5555);
  endtask

  task automatic t_hold();
    logic [W-1:0] lo = gpio_out, le = gpio_oe;
    @(negedge clk);
    c0_wvalid = 0; c0_wop = 2'd0; c0_wdata = '0;
    c1_wvalid = 0; c1_wop = 2'd0; c1_wdata = '0;
    repeat (3) @(posedge clk); #1;
    chk("R9 level held", gpio_out, lo);
    chk("R9 enable held", gpio_oe, le);
  endtask

  task automatic t_readback();
    wr(1, 0, 0, 32'h1357_9BDF, 1, 0, 1, 32'h2468_ACE0);
    c0_rsel = 0; c1_rsel = 1; #1;
    chk("R10 c0 reads level", c0_rdata, 32'h1357_9BDF);
    chk("R10 c1 reads enable", c1_rdata, 32'h2468_ACE0);
    c0_rsel = 1; c1_rsel = 0; #1;
    chk("R10 c0 reads enable", c0_rdata, 32'h2468_ACE0);
    chk("R10 c1 reads level", c1_rdata, 32'h1357_9BDF);
  endtask

  initial begin
    rst_n = 0; idle();
    c0_wop = 0; c1_wop = 0; c0_wsel = 0; c1_wsel = 0;
    c0_wdata = '0; c1_wdata = '0; c0_rsel = 0; c1_rsel = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_single_ops();
    t_pair_matrix();
    t_glitch();
    t_independent();
    t_hold();
    t_readback();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule